// File: doc/BRIEF.md
# Vectored Priority Interrupt Manager

This block collects up to 256 interrupt lines and hands the processor one winning source per interrupt class, together with the address of that source's service routine. Each source carries its own settings: an enable bit, a class bit that routes it to the normal (IRQ) or fast (FIQ) request line, a 4-bit priority and a 32-bit vector address. Two arbiters, one per class, run side by side. Each picks the enabled pending source with the smallest priority value. A ready-to-use vector is held next to a request line. The processor acknowledges with one pulse per class.

Each vector is stored with SECDED check bits. A single flipped bit is corrected on the fly and logged in a sticky status word. A double flip makes the block present a fixed default vector. Software reaches the block through a plain write/read port. Through that port it programs sources and vectors, raises any interrupt by number, reads and clears the error status, and arms a one-shot bit-flip mask that corrupts the next stored vector so the error paths can be tested.

Top module: `vim_top`

## Requirements
- R1: After reset both request lines are low, both active indices and vectors are zero, and the status word reads zero.
- R2: A source whose class bit (config bit 1) is 1 is arbitrated only on the FIQ side, and one whose class bit is 0 only on the IRQ side; both sides present winners at the same time.
- R3: A source whose enable bit (config bit 0) is 0 never raises a request, even while its input is high.
- R4: Among eligible sources of one class, the smallest priority value (config bits 7:4) wins; on equal priority the lowest source number wins.
- R5: A level-type source (config bit 2 = 0) requests while its input is high, and its request drops two clock edges after the input falls; acknowledge does not clear it.
- R6: A pulse-type source (config bit 2 = 1) stays pending after its input falls, until an acknowledge is given while it is the active source of its class.
- R7: Writing a source number to control word 0 (address region 2, index 0) makes that source pending; the software request is cleared by the acknowledge of that source.
- R8: A request line, active index and vector change on the second clock edge after a pending input is first seen, and the vector equals the value written for that source (region 1, index = source).
- R9: A vector with one flipped stored bit is presented and read back corrected; status bit 0 is set and status bits 15:8 hold the source number.
- R10: A vector with two flipped stored bits is replaced by the default vector 0xFFFFFF00, and status bit 1 is set.
- R11: The flip mask in control word 1 (bits 5:0 and 13:8 are codeword bit positions, bits 6 and 14 enable them) applies to the next vector write only and then reads back as zero.
- R12: Any write to control word 2 (status) clears the status word.
- R13: Addresses are {region[1:0], index}; a region 0 write stores enable, class, type and priority, and reading it returns the same fields in the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt source inputs |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | SRC_W+2 | Register address {region, index} |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i |
| irq_req_o | output | 1 | IRQ request |
| irq_idx_o | output | SRC_W | Active IRQ source number |
| irq_vec_o | output | 32 | Active IRQ vector |
| irq_ack_i | input | 1 | IRQ acknowledge pulse |
| fiq_req_o | output | 1 | FIQ request |
| fiq_idx_o | output | SRC_W | Active FIQ source number |
| fiq_vec_o | output | 32 | Active FIQ vector |
| fiq_ack_i | input | 1 | FIQ acknowledge pulse |

## Verification
The hardest state to reach from the ports is a stored vector holding one or two wrong bits, because every normal write produces a clean codeword. The bench arms the one-shot flip mask, writes the vector through it, and then raises that source by software so the corrupted entry becomes the active one. It then checks the presented vector, the status word and a second, clean write of the same entry. Pulse-type pending state is reached by a one-cycle input pulse, and the bench holds it across several idle cycles before the acknowledge.

// File: rtl/vim_pkg.sv
`timescale 1ns/1ps
package vim_pkg;
  localparam int unsigned CW_W = 39;
  localparam logic [1:0] RGN_CFG = 2'd0;
  localparam logic [1:0] RGN_VEC = 2'd1;
  localparam logic [1:0] RGN_CTL = 2'd2;
  localparam int unsigned CTL_SWSET = 0;
  localparam int unsigned CTL_INJ   = 1;
  localparam int unsigned CTL_STAT  = 2;

  typedef logic [CW_W-1:0] vim_cw_t;
  typedef struct packed {
    logic [31:0] data;
    logic        sec;
    logic        ded;
  } vim_dec_t;

  // Hamming positions 1..38 with check bits at powers of two, bit 0 overall parity
  function automatic vim_cw_t vim_ecc_enc(input logic [31:0] d);
    vim_cw_t cw;
    logic [5:0] syn;
    int unsigned k;
    cw = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    syn = '0;
    for (int p = 1; p < CW_W; p++) if (cw[p]) syn ^= 6'(p);
    for (int b = 0; b < 6; b++) cw[1 << b] = syn[b];
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic vim_dec_t vim_ecc_dec(input vim_cw_t cw_in);
    vim_dec_t r;
    vim_cw_t cw;
    logic [5:0] syn;
    logic par;
    int unsigned k;
    cw = cw_in;
    syn = '0;
    for (int p = 1; p < CW_W; p++) if (cw[p]) syn ^= 6'(p);
    par = ^cw;
    r.sec = 1'b0;
    r.ded = 1'b0;
    if (par) begin
      if (int'(syn) < CW_W) begin
        cw[syn] = ~cw[syn];
        r.sec = 1'b1;
      end else begin
        r.ded = 1'b1;
      end
    end else if (syn != '0) begin
      r.ded = 1'b1;
    end
    r.data = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r.data[k] = cw[p];
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] vim_vec_pick(input vim_cw_t cw, input logic [31:0] dflt);
    vim_dec_t r;
    r = vim_ecc_dec(cw);
    return (r.ded || r.sec && 1'b0) ? dflt : r.data;
  endfunction

  function automatic vim_cw_t vim_inj_mask(input logic [14:0] r);
    vim_cw_t m;
    m = '0;
    if (r[6] && int'(r[5:0]) < CW_W) m[r[5:0]] = 1'b1;
    if (r[14] && int'(r[13:8]) < CW_W) m[r[13:8]] = ~m[r[13:8]];
    return m;
  endfunction
endpackage

// File: rtl/vim_arbiter.sv
`timescale 1ns/1ps
module vim_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRI_W   = 4,
  parameter int unsigned SRC_W   = 5
) (
  input  logic [NUM_SRC-1:0]       elig_i,
  input  logic [NUM_SRC*PRI_W-1:0] pri_i,
  output logic                     found_o,
  output logic [SRC_W-1:0]         idx_o
);
  always_comb begin
    logic [PRI_W-1:0] best;
    logic             hit;
    best  = '1;
    hit   = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (elig_i[i] && (!hit || pri_i[i*PRI_W +: PRI_W] < best)) begin
        hit   = 1'b1;
        best  = pri_i[i*PRI_W +: PRI_W];
        idx_o = SRC_W'(i);
      end
    end
    found_o = hit;
  end
endmodule

// File: rtl/vim_src_bank.sv
`timescale 1ns/1ps
module vim_src_bank import vim_pkg::*; #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRI_W   = 4,
  parameter int unsigned SRC_W   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       src_i,
  input  logic                     cfg_we_i,
  input  logic                     vec_we_i,
  input  logic                     sw_we_i,
  input  logic [SRC_W-1:0]         wr_idx_i,
  input  logic [SRC_W-1:0]         sw_idx_i,
  input  logic [31:0]              wdata_i,
  input  vim_cw_t                  inj_mask_i,
  input  logic [1:0]               clr_i,
  input  logic [SRC_W-1:0]         clr_idx_i [2],
  output logic [NUM_SRC-1:0]       en_o,
  output logic [NUM_SRC-1:0]       cls_o,
  output logic [NUM_SRC-1:0]       pls_o,
  output logic [NUM_SRC*PRI_W-1:0] pri_o,
  output logic [NUM_SRC-1:0]       pend_o,
  output vim_cw_t                  cw_o [NUM_SRC]
);
  vim_cw_t wr_cw;
  assign wr_cw = vim_ecc_enc(wdata_i) ^ inj_mask_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic hit_wr, hit_sw, clr_s;
    logic en_q, cls_q, pls_q, hw_q, sw_q;
    logic [PRI_W-1:0] pri_q;
    vim_cw_t cw_q;

    assign hit_wr = (wr_idx_i == SRC_W'(s));
    assign hit_sw = sw_we_i && (sw_idx_i == SRC_W'(s));
    assign clr_s  = (clr_i[0] && clr_idx_i[0] == SRC_W'(s)) ||
                    (clr_i[1] && clr_idx_i[1] == SRC_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q  <= 1'b0;
        cls_q <= 1'b0;
        pls_q <= 1'b0;
        pri_q <= '0;
        hw_q  <= 1'b0;
        sw_q  <= 1'b0;
        cw_q  <= '0;
      end else begin
        if (cfg_we_i && hit_wr) begin
          en_q  <= wdata_i[0];
          cls_q <= wdata_i[1];
          pls_q <= wdata_i[2];
          pri_q <= wdata_i[4 +: PRI_W];
        end
        if (vec_we_i && hit_wr) cw_q <= wr_cw;
        hw_q <= pls_q ? ((hw_q & ~clr_s) | src_i[s]) : src_i[s];
        sw_q <= (sw_q & ~clr_s) | hit_sw;
      end
    end

    assign en_o[s]  = en_q;
    assign cls_o[s] = cls_q;
    assign pls_o[s] = pls_q;
    assign pri_o[s*PRI_W +: PRI_W] = pri_q;
    assign pend_o[s] = hw_q | sw_q;
    assign cw_o[s] = cw_q;
  end
endmodule

// File: rtl/vim_top.sv
`timescale 1ns/1ps
module vim_top import vim_pkg::*; #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRI_W   = 4,
  parameter logic [31:0] DEF_VEC = 32'hFFFF_FF00,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC),
  localparam int unsigned AW     = SRC_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_req_o,
  output logic [SRC_W-1:0]   irq_idx_o,
  output logic [31:0]        irq_vec_o,
  input  logic               irq_ack_i,
  output logic               fiq_req_o,
  output logic [SRC_W-1:0]   fiq_idx_o,
  output logic [31:0]        fiq_vec_o,
  input  logic               fiq_ack_i
);
  logic [1:0]       rgn;
  logic [SRC_W-1:0] ridx;
  logic cfg_we, vec_we, sw_we, inj_we, st_we;

  assign rgn    = bus_addr_i[AW-1 -: 2];
  assign ridx   = bus_addr_i[SRC_W-1:0];
  assign cfg_we = bus_we_i && rgn == RGN_CFG;
  assign vec_we = bus_we_i && rgn == RGN_VEC;
  assign sw_we  = bus_we_i && rgn == RGN_CTL && ridx == SRC_W'(CTL_SWSET);
  assign inj_we = bus_we_i && rgn == RGN_CTL && ridx == SRC_W'(CTL_INJ);
  assign st_we  = bus_we_i && rgn == RGN_CTL && ridx == SRC_W'(CTL_STAT);

  // one-shot flip mask for the next vector write
  logic [14:0] inj_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inj_q <= '0;
    else if (inj_we) inj_q <= bus_wdata_i[14:0];
    else if (vec_we) inj_q <= '0;
  end

  logic [NUM_SRC-1:0]       en_vec, cls_vec, pls_vec, pend_vec;
  logic [NUM_SRC*PRI_W-1:0] pri_vec;
  vim_cw_t                  vec_cw [NUM_SRC];
  logic [1:0]               ack_w, clr_w, found_w, sec_ev, ded_ev, req_w;
  logic [SRC_W-1:0]         win_idx [2];
  logic [SRC_W-1:0]         act_idx [2];
  logic [31:0]              act_vec [2];

  assign ack_w = {fiq_ack_i, irq_ack_i};

  vim_src_bank #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .SRC_W(SRC_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .cfg_we_i   (cfg_we),
    .vec_we_i   (vec_we),
    .sw_we_i    (sw_we),
    .wr_idx_i   (ridx),
    .sw_idx_i   (bus_wdata_i[SRC_W-1:0]),
    .wdata_i    (bus_wdata_i),
    .inj_mask_i (vim_inj_mask(inj_q)),
    .clr_i      (clr_w),
    .clr_idx_i  (act_idx),
    .en_o       (en_vec),
    .cls_o      (cls_vec),
    .pls_o      (pls_vec),
    .pri_o      (pri_vec),
    .pend_o     (pend_vec),
    .cw_o       (vec_cw)
  );

  // c = 0: IRQ side, c = 1: FIQ side
  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [NUM_SRC-1:0] elig;
    vim_dec_t           dec;
    logic [31:0]        win_vec;
    logic               r_q;
    logic [SRC_W-1:0]   i_q;
    logic [31:0]        v_q;

    assign elig = pend_vec & en_vec & ((c == 1) ? cls_vec : ~cls_vec);

    vim_arbiter #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .SRC_W(SRC_W)) u_arb (
      .elig_i  (elig),
      .pri_i   (pri_vec),
      .found_o (found_w[c]),
      .idx_o   (win_idx[c])
    );

    assign dec       = vim_ecc_dec(vec_cw[win_idx[c]]);
    assign win_vec   = dec.ded ? DEF_VEC : dec.data;
    assign sec_ev[c] = found_w[c] & dec.sec;
    assign ded_ev[c] = found_w[c] & dec.ded;
    assign clr_w[c]  = ack_w[c] & r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= 1'b0;
        i_q <= '0;
        v_q <= '0;
      end else begin
        r_q <= found_w[c];
        i_q <= found_w[c] ? win_idx[c] : '0;
        v_q <= found_w[c] ? win_vec : '0;
      end
    end

    assign req_w[c]   = r_q;
    assign act_idx[c] = i_q;
    assign act_vec[c] = v_q;
  end

  assign irq_req_o = req_w[0];
  assign irq_idx_o = act_idx[0];
  assign irq_vec_o = act_vec[0];
  assign fiq_req_o = req_w[1];
  assign fiq_idx_o = act_idx[1];
  assign fiq_vec_o = act_vec[1];

  // sticky error status
  logic             st_sec_q, st_ded_q;
  logic [SRC_W-1:0] st_src_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_sec_q <= 1'b0;
      st_ded_q <= 1'b0;
      st_src_q <= '0;
    end else begin
      if (st_we) begin
        st_sec_q <= 1'b0;
        st_ded_q <= 1'b0;
        st_src_q <= '0;
      end
      if (|sec_ev) st_sec_q <= 1'b1;
      if (|ded_ev) st_ded_q <= 1'b1;
      if (sec_ev[1] | ded_ev[1])      st_src_q <= win_idx[1];
      else if (sec_ev[0] | ded_ev[0]) st_src_q <= win_idx[0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (rgn)
      RGN_CFG: begin
        bus_rdata_o[0] = en_vec[ridx];
        bus_rdata_o[1] = cls_vec[ridx];
        bus_rdata_o[2] = pls_vec[ridx];
        bus_rdata_o[4 +: PRI_W] = pri_vec[ridx*PRI_W +: PRI_W];
      end
      RGN_VEC: bus_rdata_o = vim_vec_pick(vec_cw[ridx], DEF_VEC);
      RGN_CTL: begin
        if (ridx == SRC_W'(CTL_INJ)) bus_rdata_o[14:0] = inj_q;
        else if (ridx == SRC_W'(CTL_STAT)) begin
          bus_rdata_o[0] = st_sec_q;
          bus_rdata_o[1] = st_ded_q;
          bus_rdata_o[8 +: SRC_W] = st_src_q;
        end
      end
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vim_checker.sv
`timescale 1ns/1ps
module vim_checker #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned SRC_W   = 5,
  parameter logic [31:0] DEF_VEC = 32'hFFFF_FF00
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_req_o,
  input logic [SRC_W-1:0]   irq_idx_o,
  input logic [31:0]        irq_vec_o,
  input logic               fiq_req_o,
  input logic [SRC_W-1:0]   fiq_idx_o,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] cls_vec,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [1:0]         sec_ev,
  input logic [1:0]         ded_ev,
  input logic               st_sec_q
);
  logic [NUM_SRC-1:0] en_d, cls_d, pend_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d   <= '0;
      cls_d  <= '0;
      pend_d <= '0;
    end else begin
      en_d   <= en_vec;
      cls_d  <= cls_vec;
      pend_d <= pend_vec;
    end
  end

  a_r2_irq_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> !cls_d[irq_idx_o]);
  a_r2_fiq_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_req_o |-> cls_d[fiq_idx_o]);
  a_r3_enabled_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o |-> en_d[irq_idx_o]) and (fiq_req_o |-> en_d[fiq_idx_o]));
  a_r8_req_has_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|pend_d) |-> (!irq_req_o && !fiq_req_o));
  a_r9_sec_logged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sec_ev) |=> st_sec_q);
  a_r10_ded_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ded_ev[0] |=> (irq_vec_o == DEF_VEC));
endmodule

bind vim_top vim_checker #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .DEF_VEC(DEF_VEC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_req_o (irq_req_o),
  .irq_idx_o (irq_idx_o),
  .irq_vec_o (irq_vec_o),
  .fiq_req_o (fiq_req_o),
  .fiq_idx_o (fiq_idx_o),
  .en_vec    (en_vec),
  .cls_vec   (cls_vec),
  .pend_vec  (pend_vec),
  .sec_ev    (sec_ev),
  .ded_ev    (ded_ev),
  .st_sec_q  (st_sec_q)
);

// File: tb/tb_vim_top.sv
`timescale 1ns/1ps
module tb_vim_top;
  localparam int NS = 32;
  localparam int SW = 5;
  localparam int AW = 7;
  localparam logic [31:0] DEFV = 32'hFFFF_FF00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic irq_req, fiq_req, irq_ack = 1'b0, fiq_ack = 1'b0;
  logic [SW-1:0] irq_idx, fiq_idx;
  logic [31:0] irq_vec, fiq_vec;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  vim_top dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_req_o(irq_req), .irq_idx_o(irq_idx), .irq_vec_o(irq_vec), .irq_ack_i(irq_ack),
    .fiq_req_o(fiq_req), .fiq_idx_o(fiq_idx), .fiq_vec_o(fiq_vec), .fiq_ack_i(fiq_ack)
  );

  always #4 clk = ~clk;

  function automatic logic [AW-1:0] a(input int rg, input int ix);
    return AW'((rg << SW) | ix);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] ad, input logic [31:0] d);
    we = 1'b1; addr = ad; wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] ad, output logic [31:0] d);
    addr = ad;
    #1;
    d = rdata;
  endtask

  task automatic cfg(input int s, input bit en, input bit fiq, input bit pulse, input int pri);
    wr(a(0, s), {24'b0, 4'(pri), 1'b0, pulse, fiq, en});
  endtask

  task automatic ack_irq();
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 fiq_req", 32'(fiq_req), 0);
    chk("R1 irq_vec", irq_vec, 0);
    rd(a(2, 2), rv); chk("R1 status", rv, 0);
  endtask

  task automatic t_readback();
    cfg(5, 1'b1, 1'b1, 1'b1, 9);
    rd(a(0, 5), rv); chk("R13 config readback", rv, 32'h97);
    cfg(5, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic t_level();
    cfg(3, 1'b1, 1'b0, 1'b0, 4);
    wr(a(1, 3), 32'h1000_0300);
    src[3] = 1'b1;
    tick(1); chk("R8 not yet after one edge", 32'(irq_req), 0);
    tick(1);
    chk("R8 req", 32'(irq_req), 1);
    chk("R8 idx", 32'(irq_idx), 3);
    chk("R8 vector", irq_vec, 32'h1000_0300);
    src[3] = 1'b0;
    tick(2); chk("R5 level drop", 32'(irq_req), 0);
  endtask

  task automatic t_disabled();
    wr(a(1, 7), 32'h7777_0007);
    src[7] = 1'b1;
    tick(3);
    chk("R3 disabled irq", 32'(irq_req), 0);
    chk("R3 disabled fiq", 32'(fiq_req), 0);
    src[7] = 1'b0;
    tick(2);
  endtask

  task automatic t_prio();
    cfg(10, 1'b1, 1'b0, 1'b0, 2);
    cfg(12, 1'b1, 1'b0, 1'b0, 2);
    cfg(20, 1'b1, 1'b0, 1'b0, 1);
    src[10] = 1'b1; src[12] = 1'b1;
    tick(2); chk("R4 tie lowest index", 32'(irq_idx), 10);
    src[20] = 1'b1;
    tick(2); chk("R4 smaller value wins", 32'(irq_idx), 20);
    src[10] = 1'b0; src[12] = 1'b0; src[20] = 1'b0;
    tick(2); chk("R5 all dropped", 32'(irq_req), 0);
  endtask

  task automatic t_fiq();
    cfg(9, 1'b1, 1'b1, 1'b0, 5);
    wr(a(1, 9), 32'h9999_0009);
    src[9] = 1'b1; src[3] = 1'b1;
    tick(2);
    chk("R2 fiq req", 32'(fiq_req), 1);
    chk("R2 fiq idx", 32'(fiq_idx), 9);
    chk("R2 fiq vec", fiq_vec, 32'h9999_0009);
    chk("R2 irq side idx", 32'(irq_idx), 3);
    src[9] = 1'b0; src[3] = 1'b0;
    tick(2);
  endtask

  task automatic t_pulse();
    cfg(14, 1'b1, 1'b0, 1'b1, 0);
    src[14] = 1'b1;
    tick(1);
    src[14] = 1'b0;
    tick(4);
    chk("R6 pulse held", 32'(irq_req), 1);
    chk("R6 pulse idx", 32'(irq_idx), 14);
    ack_irq();
    chk("R6 cleared by ack", 32'(irq_req), 0);
  endtask

  task automatic t_sw();
    cfg(17, 1'b1, 1'b0, 1'b0, 3);
    wr(a(2, 0), 17);
    tick(1);
    chk("R7 sw req", 32'(irq_req), 1);
    chk("R7 sw idx", 32'(irq_idx), 17);
    ack_irq();
    chk("R7 sw cleared", 32'(irq_req), 0);
  endtask

  task automatic t_sec();
    cfg(22, 1'b1, 1'b0, 1'b0, 0);
    wr(a(2, 1), 32'h0000_0045);
    wr(a(1, 22), 32'hCAFE_0022);
    wr(a(2, 0), 22);
    tick(1);
    chk("R9 corrected vector", irq_vec, 32'hCAFE_0022);
    rd(a(2, 2), rv); chk("R9 status", rv, 32'h0000_1601);
    rd(a(1, 22), rv); chk("R9 corrected readback", rv, 32'hCAFE_0022);
    ack_irq();
    wr(a(2, 2), 0);
    rd(a(2, 2), rv); chk("R12 status cleared", rv, 0);
  endtask

  task automatic t_ded();
    cfg(23, 1'b1, 1'b0, 1'b0, 0);
    wr(a(2, 1), 32'h0000_4A43);
    wr(a(1, 23), 32'h1234_5678);
    rd(a(2, 1), rv); chk("R11 mask consumed", rv, 0);
    wr(a(2, 0), 23);
    tick(1);
    chk("R10 default vector", irq_vec, DEFV);
    rd(a(2, 2), rv); chk("R10 status", rv, 32'h0000_1702);
    ack_irq();
    wr(a(2, 2), 0);
    wr(a(1, 23), 32'h1234_5678);
    wr(a(2, 0), 23);
    tick(1);
    chk("R11 clean rewrite", irq_vec, 32'h1234_5678);
    rd(a(2, 2), rv); chk("R11 no new error", rv, 0);
    ack_irq();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_readback();
    t_level();
    t_disabled();
    t_prio();
    t_fiq();
    t_pulse();
    t_sw();
    t_sec();
    t_ded();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule